// File: doc/BRIEF.md
# Fractional Clock Counter with Complement-Encoded Ratio Fields

This block turns a steady input clock into a fractional clock whose average rate is the input rate times m over n. It runs in the input clock domain. Its output, `frac_tick`, is a registered clock-enable: it is high in the cycles where the fractional clock has an edge. The ratio comes from three register fields of parameterised width. The numerator field holds m directly. The denominator field holds the bitwise complement of (n - m), and the third field holds the bitwise complement of n. The block decodes these fields itself and shows the decoded ratio on readback ports.

A phase accumulator adds m every input cycle. When the sum reaches n, it subtracts n and emits one tick, so m ticks fall in every n input cycles. The counter runs only when the mode enable is set, n is nonzero and m differs from n. Any other setting passes the input through: a tick in every cycle. A setting with m equal to zero and a nonzero n stops the output.

New field values take effect only after a `commit` pulse. While the counter is running, the block holds the committed values in a staging register until the accumulator wraps, so a period already in progress is never cut short.

The controller has four states:
- ST_BYPASS: a tick in every cycle.
- ST_RUN: accumulator counting.
- ST_PEND: counting, with a commit waiting for the next wrap.
- ST_HALT: output silent.

A wrap happens in every cycle in ST_BYPASS and ST_HALT, and on an accumulator overflow in ST_RUN and ST_PEND. The transitions are:
- Adopt: a wrap that meets a commit in the same cycle, or that occurs in ST_PEND. It moves the block to ST_BYPASS, ST_RUN or ST_HALT, depending on the adopted setting.
- Defer: a commit in ST_RUN or ST_PEND without an overflow. It moves the block to ST_PEND.
- Hold: every other cycle. The state does not change.

Top module: `frac_clk_counter`

## Requirements
- R1: While reset is asserted, `frac_tick`, `rb_m`, `rb_n`, `rb_d`, `rb_counting` and `rb_pending` are all zero, and the adopted setting is bypass.
- R2: After a setting is adopted, `rb_m` equals the numerator field, and `rb_n` equals (bitwise complement of the denominator field, as an unsigned value of CNT_W bits) + m, computed in CNT_W+1 bits. `rb_d` equals the bitwise complement of the third field.
- R3: In counting mode, starting from the adoption edge, every window of n consecutive input cycles holds exactly m cycles with `frac_tick` high.
- R4: When the adopted mode enable is 0, `frac_tick` is high in every cycle, starting with the edge after adoption.
- R5: A decoded n of zero is treated as bypass: a tick in every cycle, and `rb_counting` low.
- R6: When the decoded m equals the decoded n, the counter is not used and the output is bypass.
- R7: A commit made while counting is adopted only at the edge where the accumulator overflows. Until then `rb_pending` is 1 and the readback keeps the old values. The adopted values are those present at the commit edge; field changes made without a commit have no effect.
- R8: A commit made in bypass or halt is adopted at the same edge, so `rb_pending` stays 0.
- R9: `rb_counting` is 1 exactly when the adopted setting has the enable set, n nonzero, m nonzero and m different from n.
- R10: An adopted setting with the enable set, m zero and n nonzero holds `frac_tick` at 0, and a later commit is still adopted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_en | input | 1 | Counter mode enable for the next commit |
| commit | input | 1 | One-cycle pulse that captures the three fields and the enable |
| m_reg | input | CNT_W | Numerator field m |
| n_reg | input | CNT_W | Complement of (n - m) |
| d_reg | input | CNT_W | Complement of n |
| frac_tick | output | 1 | Fractional clock-enable, registered |
| rb_m | output | CNT_W | Adopted numerator |
| rb_n | output | CNT_W+1 | Adopted, decoded denominator |
| rb_d | output | CNT_W | Adopted, decoded third field |
| rb_counting | output | 1 | The accumulator is in use |
| rb_pending | output | 1 | A commit is waiting for a wrap |

## Verification
A wrong accumulator value changes the number of ticks in an n-cycle window. The error shows within one window of n cycles after adoption, which is why every table vector counts ticks over exactly that span. A wrong state, such as a missed ST_PEND or a premature adoption, shows at once on `rb_pending` or `rb_m`, or as a pending interval that is too short or too long. The directed case measures that interval cycle by cycle. A bad decode shows on `rb_n` or `rb_d` in the first cycle after adoption.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_RUN    = 2'd1,
        ST_PEND   = 2'd2,
        ST_HALT   = 2'd3
    } fc_state_e;
endpackage

// File: rtl/fc_field_decode.sv
// Turns the complement-encoded register fields into plain ratio values.
module fc_field_decode #(
    parameter int FW = 8
) (
    input  logic [FW-1:0] m_raw,
    input  logic [FW-1:0] n_raw,
    input  logic [FW-1:0] d_raw,
    output logic [FW-1:0] m_dec,
    output logic [FW:0]   n_dec,
    output logic [FW-1:0] d_dec
);
    always_comb begin
        m_dec = m_raw;
        n_dec = {1'b0, ~n_raw} + {1'b0, m_raw};
        d_dec = ~d_raw;
    end
endmodule

// File: rtl/fc_accum.sv
// Phase accumulator: adds m each cycle and wraps modulo n.
module fc_accum #(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [FW-1:0] step_m,
    input  logic [FW:0]   mod_n,
    output logic          ovf,
    output logic [FW:0]   acc_q
);
    localparam int SW = FW + 2;

    logic [SW-1:0] sum;
    logic [SW-1:0] nxt;

    always_comb begin
        sum = SW'(acc_q) + SW'(step_m);
        ovf = run && (sum >= SW'(mod_n));
        nxt = ovf ? (sum - SW'(mod_n)) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= '0;
        end else if (run) begin
            acc_q <= nxt[FW:0];
        end
    end

    // Residue stays below the modulus while counting.
    assert_acc_below_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < mod_n));
endmodule

// File: rtl/fc_ctrl.sv
// Mode controller: staging, adoption at wrap, tick generation.
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          mode_en,
    input  logic [FW-1:0] m_in,
    input  logic [FW:0]   n_in,
    input  logic [FW-1:0] d_in,
    input  logic          ovf,
    output fc_state_e     state_q,
    output logic [FW-1:0] act_m,
    output logic [FW:0]   act_n,
    output logic [FW-1:0] act_d,
    output logic          load,
    output logic          run,
    output logic          tick_q
);
    logic          stg_en;
    logic [FW-1:0] stg_m;
    logic [FW:0]   stg_n;
    logic [FW-1:0] stg_d;

    logic          wrap;
    logic          adopt;
    logic          src_en;
    logic [FW-1:0] src_m;
    logic [FW:0]   src_n;
    logic [FW-1:0] src_d;
    fc_state_e     state_d;
    logic          tick_d;

    function automatic fc_state_e classify(input logic en, input logic [FW-1:0] m,
                                           input logic [FW:0] n);
        if (!en || (n == '0) || ({1'b0, m} == n)) begin
            return ST_BYPASS;
        end else if (m == '0) begin
            return ST_HALT;
        end
        return ST_RUN;
    endfunction

    // Next-state logic
    always_comb begin
        src_en = commit ? mode_en : stg_en;
        src_m  = commit ? m_in    : stg_m;
        src_n  = commit ? n_in    : stg_n;
        src_d  = commit ? d_in    : stg_d;
        unique case (state_q)
            ST_BYPASS, ST_HALT: wrap = 1'b1;
            ST_RUN, ST_PEND:    wrap = ovf;
            default:            wrap = 1'b1;
        endcase
        adopt   = wrap && (commit || (state_q == ST_PEND));
        state_d = state_q;
        if (adopt) begin
            state_d = classify(src_en, src_m, src_n);
        end else if (commit) begin
            state_d = ST_PEND;
        end
    end

    // State register, adopted setting and staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            act_m   <= '0;
            act_n   <= '0;
            act_d   <= '0;
            stg_en  <= 1'b0;
            stg_m   <= '0;
            stg_n   <= '0;
            stg_d   <= '0;
        end else begin
            state_q <= state_d;
            if (commit) begin
                stg_en <= mode_en;
                stg_m  <= m_in;
                stg_n  <= n_in;
                stg_d  <= d_in;
            end
            if (adopt) begin
                act_m <= src_m;
                act_n <= src_n;
                act_d <= src_d;
            end
        end
    end

    // Outputs
    always_comb begin
        run  = (state_q == ST_RUN) || (state_q == ST_PEND);
        load = adopt;
        unique case (state_q)
            ST_BYPASS:       tick_d = 1'b1;
            ST_RUN, ST_PEND: tick_d = ovf;
            ST_HALT:         tick_d = 1'b0;
            default:         tick_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assert_hold_until_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ovf) |=> ($stable(act_m) && $stable(act_n)));
    assert_counting_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ((act_n != '0) && (act_m != '0) && ({1'b0, act_m} != act_n)));
    assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> !tick_q);
    assert_bypass_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BYPASS) |=> tick_q);
endmodule

// File: rtl/frac_clk_counter.sv
module frac_clk_counter
    import fc_pkg::*;
#(
    parameter  int CNT_W = 8,
    localparam int FW    = (CNT_W > 0) ? CNT_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          commit,
    input  logic [FW-1:0] m_reg,
    input  logic [FW-1:0] n_reg,
    input  logic [FW-1:0] d_reg,
    output logic          frac_tick,
    output logic [FW-1:0] rb_m,
    output logic [FW:0]   rb_n,
    output logic [FW-1:0] rb_d,
    output logic          rb_counting,
    output logic          rb_pending
);
    generate
        if (CNT_W == 0) begin : g_absent
            logic pass_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pass_q <= 1'b0;
                else        pass_q <= 1'b1;
            end
            assign frac_tick   = pass_q;
            assign rb_m        = '0;
            assign rb_n        = '0;
            assign rb_d        = '0;
            assign rb_counting = 1'b0;
            assign rb_pending  = 1'b0;
        end else begin : g_counter
            logic [FW-1:0] dm;
            logic [FW:0]   dn;
            logic [FW-1:0] dd;
            logic          ovf;
            logic [FW:0]   acc;
            logic          load;
            logic          run;
            fc_state_e     st;

            fc_field_decode #(.FW(FW)) u_dec (
                .m_raw(m_reg), .n_raw(n_reg), .d_raw(d_reg),
                .m_dec(dm), .n_dec(dn), .d_dec(dd)
            );

            fc_ctrl #(.FW(FW)) u_ctrl (
                .clk(clk), .rst_n(rst_n), .commit(commit), .mode_en(mode_en),
                .m_in(dm), .n_in(dn), .d_in(dd), .ovf(ovf),
                .state_q(st), .act_m(rb_m), .act_n(rb_n), .act_d(rb_d),
                .load(load), .run(run), .tick_q(frac_tick)
            );

            fc_accum #(.FW(FW)) u_acc (
                .clk(clk), .rst_n(rst_n), .run(run), .load(load),
                .step_m(rb_m), .mod_n(rb_n), .ovf(ovf), .acc_q(acc)
            );

            assign rb_counting = run;
            assign rb_pending  = (st == ST_PEND);

            assert_pending_while_counting_R7: assert property (@(posedge clk) disable iff (!rst_n)
                rb_pending |-> rb_counting);
            assert_one_tick_per_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (rb_counting && !ovf) |=> !frac_tick);
        end
    endgenerate
endmodule

// File: tb/sim_frac_clk_counter.sv
module sim_frac_clk_counter;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 10;
    // {enable, m, n, class}; class 0 bypass, 1 run, 2 halt
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 8'd3,   9'd8,   2'd1},
        {1'b1, 8'd1,   9'd2,   2'd1},
        {1'b1, 8'd5,   9'd5,   2'd0},
        {1'b0, 8'd3,   9'd8,   2'd0},
        {1'b1, 8'd7,   9'd10,  2'd1},
        {1'b1, 8'd0,   9'd4,   2'd2},
        {1'b1, 8'd254, 9'd255, 2'd1},
        {1'b1, 8'd1,   9'd1,   2'd0},
        {1'b1, 8'd0,   9'd0,   2'd0},
        {1'b1, 8'd200, 9'd455, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0;
    logic commit = 1'b0;
    logic [W-1:0] m_reg = '0;
    logic [W-1:0] n_reg = '0;
    logic [W-1:0] d_reg = '0;
    logic frac_tick;
    logic [W-1:0] rb_m;
    logic [W:0] rb_n;
    logic [W-1:0] rb_d;
    logic rb_counting;
    logic rb_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_clk_counter #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .commit(commit),
        .m_reg(m_reg), .n_reg(n_reg), .d_reg(d_reg), .frac_tick(frac_tick),
        .rb_m(rb_m), .rb_n(rb_n), .rb_d(rb_d),
        .rb_counting(rb_counting), .rb_pending(rb_pending)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic en, input logic [W-1:0] m, input logic [W:0] n);
        logic [W:0] diff;
        diff    = n - {1'b0, m};
        mode_en = en;
        m_reg   = m;
        n_reg   = ~diff[W-1:0];
        d_reg   = ~n[W-1:0];
    endtask

    // Commit and wait for adoption; returns rb_pending seen right after the commit edge.
    task automatic apply(input logic en, input logic [W-1:0] m, input logic [W:0] n,
                         output bit pend_after);
        drive(en, m, n);
        commit = 1'b1;
        step();
        commit = 1'b0;
        pend_after = rb_pending;
        for (int g = 0; g < 2000 && rb_pending; g++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit pa;
        int prev_cls;
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk(frac_tick == 1'b0, "R1 frac_tick in reset", int'(frac_tick), 0);
        chk(rb_m == 0 && rb_n == 0 && rb_d == 0, "R1 readback in reset", int'(rb_n), 0);
        chk(!rb_counting && !rb_pending, "R1 flags in reset", int'(rb_counting), 0);
        rst_n = 1'b1;
        step();
        chk(frac_tick == 1'b1, "R1 bypass after reset", int'(frac_tick), 1);

        // Table walk: R2 R3 R4 R5 R6 R8 R9 R10
        prev_cls = 0;
        for (int v = 0; v < NV; v++) begin
            logic en;
            logic [W-1:0] m;
            logic [W:0] n;
            int cls, len, cnt, expc;
            en  = VEC[v][19];
            m   = VEC[v][18:11];
            n   = VEC[v][10:2];
            cls = int'(VEC[v][1:0]);
            apply(en, m, n, pa);
            if (prev_cls != 1)
                chk(pa == 1'b0, "R8 immediate adoption", int'(pa), 0);
            chk(rb_m == m, "R2 rb_m", int'(rb_m), int'(m));
            chk(rb_n == n, "R2 rb_n", int'(rb_n), int'(n));
            chk(rb_d == n[W-1:0], "R2 rb_d", int'(rb_d), int'(n[W-1:0]));
            chk(rb_counting == (cls == 1), "R9 rb_counting", int'(rb_counting), int'(cls == 1));
            len = (n == 0) ? 8 : int'(n);
            cnt = 0;
            for (int k = 0; k < len; k++) begin
                step();
                cnt += int'(frac_tick);
            end
            expc = (cls == 1) ? int'(m) : ((cls == 2) ? 0 : len);
            if (cls == 1)
                chk(cnt == expc, "R3 ticks per n cycles", cnt, expc);
            else if (cls == 2)
                chk(cnt == expc, "R10 halt silent", cnt, expc);
            else if (!en)
                chk(cnt == expc, "R4 disabled bypass", cnt, expc);
            else if (n == 0)
                chk(cnt == expc, "R5 zero n bypass", cnt, expc);
            else
                chk(cnt == expc, "R6 equal m n bypass", cnt, expc);
            prev_cls = cls;
        end

        // R7: deferred adoption while counting
        apply(1'b1, 8'd1, 9'd8, pa);
        drive(1'b1, 8'd3, 9'd8);
        commit = 1'b1;
        step();
        commit = 1'b0;
        drive(1'b1, 8'd5, 9'd9);
        chk(rb_pending == 1'b1, "R7 pending set", int'(rb_pending), 1);
        chk(rb_m == 8'd1, "R7 old m kept", int'(rb_m), 1);
        begin
            int waits = 0;
            for (int g = 0; g < 100 && rb_pending; g++) begin
                step();
                waits++;
            end
            chk(waits == 7, "R7 adoption at wrap", waits, 7);
            chk(frac_tick == 1'b1, "R7 tick at wrap edge", int'(frac_tick), 1);
        end
        chk(rb_m == 8'd3, "R7 committed m adopted", int'(rb_m), 3);
        chk(rb_n == 9'd8, "R7 uncommitted field ignored", int'(rb_n), 8);
        begin
            int cnt = 0;
            for (int k = 0; k < 16; k++) begin
                step();
                cnt += int'(frac_tick);
            end
            chk(cnt == 6, "R7 ratio after adoption", cnt, 6);
            chk(rb_m == 8'd3, "R7 no change without commit", int'(rb_m), 3);
        end

        // R10: commit out of halt is immediate
        apply(1'b1, 8'd0, 9'd6, pa);
        apply(1'b1, 8'd2, 9'd6, pa);
        chk(pa == 1'b0 && rb_m == 8'd2, "R10 leave halt at once", int'(pa), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule